// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor built around one accumulator. It reaches a synchronous, word-addressed memory through a memory address register and a memory data register, and every memory access uses them. It repeats an instruction cycle of fetch, decode and execute until it decodes a halt. Each instruction word holds a 4-bit operation code in bits 15:12 and a 12-bit direct operand address in bits 11:0.

The instruction set works directly on memory. Load, add and subtract read an operand cell into the accumulator path. Store and clear write a cell. Increment and decrement read a cell, change it and write it back. Compare sets three condition flags, and a family of jumps reads those flags.

A sequencer drives all of this. It walks through named states:

- **Fetch path:** FETCH_MAR → FETCH_REQ → FETCH_MDR → FETCH_IR → DECODE.
- **From DECODE:**
  - load, add, subtract, compare, increment and decrement go to EXEC_REQ;
  - store and clear go to STORE_WR;
  - a jump goes back to FETCH_MAR;
  - halt goes to HALTED.
- **Operand path:** EXEC_REQ → EXEC_MDR → EXEC_ALU.
- **From EXEC_ALU:** increment and decrement go to STORE_WR; every other operation goes to FETCH_MAR.
- **STORE_WR** returns to FETCH_MAR.
- **HALTED** stays in HALTED until reset.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to START_ADDR and sets the accumulator, instruction register and flags to zero. It also enters FETCH_MAR, so halted, mem_fetch and mem_store are all low in the first cycle after reset.
- R2: Fetch copies the PC into the address register, then pulses mem_fetch for one cycle. The read word reaches the data register one cycle later and is then moved into the instruction register, while the PC advances by one modulo 2^12.
- R3: The operation codes for the accumulator are 0000 (load), 0011 (add) and 0101 (subtract). They put CON(X), R+CON(X) or R−CON(X) into R, and all arithmetic wraps modulo 2^16.
- R4: The operation codes for storing are 0001 (store R to X) and 0010 (clear X to zero). The address register and data register are loaded first, and then mem_store is pulsed for exactly one cycle with mem_addr=X and mem_wdata equal to the value.
- R5: The operation codes for read-modify-write are 0100 (increment) and 0110 (decrement). Each reads CON(X), changes the data register by ±1 modulo 2^16, and writes the result back to the same address without reloading the address register.
- R6: Compare (0111) makes an unsigned comparison of CON(X) against R. flags_out holds GT in bit 2, EQ in bit 1 and LT in bit 0, so exactly one of them becomes set. R is left unchanged.
- R7: The jump operation codes are 1000 (always), 1001 (GT), 1010 (EQ), 1011 (LT), 1100 (GT or EQ), 1101 (LT or EQ) and 1110 (not EQ). A jump loads the PC with X when its condition holds; otherwise execution continues at the next address.
- R8: Halt (1111) raises halted. After that, no strobe is issued and the PC, R and the flags stay frozen until reset.
- R9: Each instruction takes a fixed number of cycles:
  - jump: 5 cycles;
  - halt: 5 cycles until halted rises;
  - store or clear: 6 cycles;
  - load, add, subtract or compare: 8 cycles;
  - increment or decrement: 9 cycles.
- R10: mem_fetch and mem_store are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address, driven from the address register |
| mem_wdata | output | DATA_W | Write data, driven from the data register |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_fetch |
| mem_fetch | output | 1 | One-cycle read strobe |
| mem_store | output | 1 | One-cycle write strobe |
| halted | output | 1 | High once a halt has been decoded |
| pc_out | output | ADDR_W | Current program counter |
| acc_out | output | DATA_W | Current accumulator R |
| flags_out | output | 3 | Condition flags {GT, EQ, LT} |

## Verification
Several properties are checked on every clock:

- the reset values;
- that the two strobes never overlap and each lasts a single cycle;
- that at most one flag is set;
- that the halted state stays quiet and frozen.

Only the scenarios can show the rest. These are wrapped arithmetic results, read-modify-write write-backs, the taken and not-taken outcome of every jump condition against greater, equal and smaller operands, and the exact cycle count of each instruction class. The bench checks them against an instruction-level model that predicts the write traffic, the final registers and the memory image.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OPC_W = 4;

    localparam int FLAG_GT = 2;
    localparam int FLAG_EQ = 1;
    localparam int FLAG_LT = 0;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'b0000,
        OP_STORE = 4'b0001,
        OP_CLEAR = 4'b0010,
        OP_ADD   = 4'b0011,
        OP_INC   = 4'b0100,
        OP_SUB   = 4'b0101,
        OP_DEC   = 4'b0110,
        OP_CMP   = 4'b0111,
        OP_JMP   = 4'b1000,
        OP_JGT   = 4'b1001,
        OP_JEQ   = 4'b1010,
        OP_JLT   = 4'b1011,
        OP_JGE   = 4'b1100,
        OP_JLE   = 4'b1101,
        OP_JNE   = 4'b1110,
        OP_HALT  = 4'b1111
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH_MAR,
        ST_FETCH_REQ,
        ST_FETCH_MDR,
        ST_FETCH_IR,
        ST_DECODE,
        ST_EXEC_REQ,
        ST_EXEC_MDR,
        ST_EXEC_ALU,
        ST_STORE_WR,
        ST_HALTED
    } state_e;

    typedef enum logic [1:0] {
        MDR_SRC_MEM,
        MDR_SRC_ALU,
        MDR_SRC_ACC,
        MDR_SRC_ZERO
    } mdr_src_e;

    typedef struct packed {
        logic     mar_from_pc;
        logic     mar_from_ir;
        logic     mdr_ld;
        mdr_src_e mdr_src;
        logic     ir_ld;
        logic     pc_inc;
        logic     pc_jump;
        logic     acc_ld;
        logic     flags_ld;
        logic     mem_fetch;
        logic     mem_store;
        logic     halted;
    } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic [2:0]        cmp_flags
);

    always_comb begin
        unique case (op)
            OP_LOAD: result = operand;
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            OP_INC:  result = operand + DATA_W'(1);
            OP_DEC:  result = operand - DATA_W'(1);
            default: result = operand;
        endcase
    end

    always_comb begin
        cmp_flags          = '0;
        cmp_flags[FLAG_GT] = (operand > acc);
        cmp_flags[FLAG_EQ] = (operand == acc);
        cmp_flags[FLAG_LT] = (operand < acc);
    end

endmodule

// File: rtl/acc_branch.sv
module acc_branch
    import acc_pkg::*;
(
    input  opcode_e    op,
    input  logic [2:0] flags,
    output logic       taken
);

    logic gt, eq, lt;

    assign gt = flags[FLAG_GT];
    assign eq = flags[FLAG_EQ];
    assign lt = flags[FLAG_LT];

    always_comb begin
        unique case (op)
            OP_JMP:  taken = 1'b1;
            OP_JGT:  taken = gt;
            OP_JEQ:  taken = eq;
            OP_JLT:  taken = lt;
            OP_JGE:  taken = gt | eq;
            OP_JLE:  taken = lt | eq;
            OP_JNE:  taken = ~eq;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e op,
    input  logic    branch_taken,
    output ctrl_t   ctl
);

    state_e state_q, state_d;
    logic   is_operand_op;
    logic   is_rmw_op;
    logic   is_write_op;

    assign is_operand_op = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
                           (op == OP_CMP)  || (op == OP_INC) || (op == OP_DEC);
    assign is_rmw_op     = (op == OP_INC) || (op == OP_DEC);
    assign is_write_op   = (op == OP_STORE) || (op == OP_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH_MAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_MAR: state_d = ST_FETCH_REQ;
            ST_FETCH_REQ: state_d = ST_FETCH_MDR;
            ST_FETCH_MDR: state_d = ST_FETCH_IR;
            ST_FETCH_IR:  state_d = ST_DECODE;
            ST_DECODE: begin
                if (op == OP_HALT)      state_d = ST_HALTED;
                else if (is_operand_op) state_d = ST_EXEC_REQ;
                else if (is_write_op)   state_d = ST_STORE_WR;
                else                    state_d = ST_FETCH_MAR;
            end
            ST_EXEC_REQ:  state_d = ST_EXEC_MDR;
            ST_EXEC_MDR:  state_d = ST_EXEC_ALU;
            ST_EXEC_ALU:  state_d = is_rmw_op ? ST_STORE_WR : ST_FETCH_MAR;
            ST_STORE_WR:  state_d = ST_FETCH_MAR;
            ST_HALTED:    state_d = ST_HALTED;
            default:      state_d = ST_FETCH_MAR;
        endcase
    end

    always_comb begin
        ctl         = '0;
        ctl.mdr_src = MDR_SRC_MEM;
        unique case (state_q)
            ST_FETCH_MAR: ctl.mar_from_pc = 1'b1;
            ST_FETCH_REQ: ctl.mem_fetch   = 1'b1;
            ST_FETCH_MDR: ctl.mdr_ld      = 1'b1;
            ST_FETCH_IR: begin
                ctl.ir_ld  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_DECODE: begin
                ctl.mar_from_ir = is_operand_op || is_write_op;
                if (op == OP_STORE) begin
                    ctl.mdr_ld  = 1'b1;
                    ctl.mdr_src = MDR_SRC_ACC;
                end else if (op == OP_CLEAR) begin
                    ctl.mdr_ld  = 1'b1;
                    ctl.mdr_src = MDR_SRC_ZERO;
                end
                ctl.pc_jump = branch_taken;
            end
            ST_EXEC_REQ: ctl.mem_fetch = 1'b1;
            ST_EXEC_MDR: ctl.mdr_ld    = 1'b1;
            ST_EXEC_ALU: begin
                ctl.acc_ld   = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB);
                ctl.flags_ld = (op == OP_CMP);
                if (is_rmw_op) begin
                    ctl.mdr_ld  = 1'b1;
                    ctl.mdr_src = MDR_SRC_ALU;
                end
            end
            ST_STORE_WR: ctl.mem_store = 1'b1;
            ST_HALTED:   ctl.halted    = 1'b1;
            default:     ctl.halted    = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter int              DATA_W     = 16,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic [2:0]        flags,
    output opcode_e           op
);

    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] alu_result;
    logic [2:0]        alu_flags;
    logic [ADDR_W-1:0] ir_addr;

    assign op      = opcode_e'(ir[DATA_W-1 -: OPC_W]);
    assign ir_addr = ir[ADDR_W-1:0];

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (op),
        .acc       (acc),
        .operand   (mdr),
        .result    (alu_result),
        .cmp_flags (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= START_ADDR;
            mar   <= '0;
            mdr   <= '0;
            ir    <= '0;
            acc   <= '0;
            flags <= '0;
        end else begin
            if (ctl.mar_from_pc) mar <= pc;
            else if (ctl.mar_from_ir) mar <= ir_addr;

            if (ctl.mdr_ld) begin
                unique case (ctl.mdr_src)
                    MDR_SRC_MEM:  mdr <= mem_rdata;
                    MDR_SRC_ALU:  mdr <= alu_result;
                    MDR_SRC_ACC:  mdr <= acc;
                    MDR_SRC_ZERO: mdr <= '0;
                    default:      mdr <= mem_rdata;
                endcase
            end

            if (ctl.ir_ld) ir <= mdr;

            if (ctl.pc_jump) pc <= ir_addr;
            else if (ctl.pc_inc) pc <= pc + ADDR_W'(1);

            if (ctl.acc_ld)   acc   <= alu_result;
            if (ctl.flags_ld) flags <= alu_flags;
        end
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] START_ADDR = '0,
    localparam int               DATA_W     = ADDR_W + OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_fetch,
    output logic              mem_store,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] acc_out,
    output logic [2:0]        flags_out
);

    ctrl_t   ctl;
    opcode_e op;
    logic    taken;
    logic [2:0] flags;

    acc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .op           (op),
        .branch_taken (taken),
        .ctl          (ctl)
    );

    acc_branch u_branch (
        .op    (op),
        .flags (flags),
        .taken (taken)
    );

    acc_datapath #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .START_ADDR (START_ADDR)
    ) u_datapath (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar       (mem_addr),
        .mdr       (mem_wdata),
        .pc        (pc_out),
        .acc       (acc_out),
        .flags     (flags),
        .op        (op)
    );

    assign mem_fetch = ctl.mem_fetch;
    assign mem_store = ctl.mem_store;
    assign halted    = ctl.halted;
    assign flags_out = flags;

endmodule

// File: rtl/acc_core_checker.sv
module acc_core_checker #(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] START_ADDR = '0,
    parameter int                DATA_W     = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_fetch,
    input logic              mem_store,
    input logic              halted,
    input logic [ADDR_W-1:0] pc_out,
    input logic [DATA_W-1:0] acc_out,
    input logic [2:0]        flags_out
);

    assert_reset_values_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_out == START_ADDR) && (acc_out == '0) &&
                       (flags_out == 3'b000) && !halted && !mem_fetch && !mem_store);

    assert_fetch_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        mem_fetch |=> !mem_fetch);

    assert_store_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        mem_store |=> !mem_store && !mem_fetch);

    assert_flags_single_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags_out));

    assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc_out) && $stable(acc_out) && $stable(flags_out));

    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_fetch && !mem_store);

    assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_fetch && mem_store));

endmodule

bind acc_core acc_core_checker #(
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR),
    .DATA_W     (DATA_W)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .mem_fetch (mem_fetch),
    .mem_store (mem_store),
    .halted    (halted),
    .pc_out    (pc_out),
    .acc_out   (acc_out),
    .flags_out (flags_out)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int RUN_LIMIT = 3000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_fetch, mem_store, halted;
    logic [AW-1:0] pc_out;
    logic [DW-1:0] acc_out;
    logic [2:0]    flags_out;

    always #2.5 clk = ~clk;

    acc_core u_acc_core (
        .clk (clk), .rst (rst),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .mem_fetch (mem_fetch), .mem_store (mem_store), .halted (halted),
        .pc_out (pc_out), .acc_out (acc_out), .flags_out (flags_out)
    );

    logic [DW-1:0] mem [256];
    logic [DW-1:0] img [256];
    logic [27:0]   exp_q [$];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (mem_fetch) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_store) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every-clock comparison of write traffic against the model's queue
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_fetch && mem_store) check("R10 strobe overlap", 1, 0);
            if (mem_store) begin
                if (exp_q.size() == 0) check("R4 R5 unexpected store", {4'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
                else check("R4 R5 store addr/data", {4'h0, mem_addr, mem_wdata}, {4'h0, exp_q.pop_front()});
            end
        end
    end

    // Instruction-level reference model
    logic [AW-1:0] m_pc;
    logic [DW-1:0] m_acc;
    logic [2:0]    m_flags;
    int            m_cycles;

    task automatic model_run();
        logic [DW-1:0] w;
        logic [3:0]    op;
        logic [AW-1:0] x;
        logic          tk;
        int            steps = 0;
        bit            stop = 0;
        m_pc = '0; m_acc = '0; m_flags = '0; m_cycles = 0;
        exp_q.delete();
        while (!stop && steps < 500) begin
            steps++;
            w = img[m_pc[7:0]];
            m_pc = m_pc + 1'b1;
            op = w[15:12];
            x = w[11:0];
            m_cycles += 5;
            case (op)
                4'h0: begin m_acc = img[x[7:0]]; m_cycles += 3; end
                4'h1: begin img[x[7:0]] = m_acc; exp_q.push_back({x, m_acc}); m_cycles += 1; end
                4'h2: begin img[x[7:0]] = '0; exp_q.push_back({x, 16'h0}); m_cycles += 1; end
                4'h3: begin m_acc = m_acc + img[x[7:0]]; m_cycles += 3; end
                4'h4: begin img[x[7:0]] = img[x[7:0]] + 1'b1; exp_q.push_back({x, img[x[7:0]]}); m_cycles += 4; end
                4'h5: begin m_acc = m_acc - img[x[7:0]]; m_cycles += 3; end
                4'h6: begin img[x[7:0]] = img[x[7:0]] - 1'b1; exp_q.push_back({x, img[x[7:0]]}); m_cycles += 4; end
                4'h7: begin
                    m_flags = {img[x[7:0]] > m_acc, img[x[7:0]] == m_acc, img[x[7:0]] < m_acc};
                    m_cycles += 3;
                end
                4'hF: stop = 1;
                default: begin
                    case (op)
                        4'h8: tk = 1;
                        4'h9: tk = m_flags[2];
                        4'hA: tk = m_flags[1];
                        4'hB: tk = m_flags[0];
                        4'hC: tk = m_flags[2] | m_flags[1];
                        4'hD: tk = m_flags[0] | m_flags[1];
                        default: tk = ~m_flags[1];
                    endcase
                    if (tk) m_pc = x;
                end
            endcase
        end
    endtask

    task automatic run_program(input string name);
        int cyc = 0;
        logic [AW-1:0] hp;
        logic [DW-1:0] ha;
        logic [2:0]    hf;
        int bad = 0;
        for (int i = 0; i < 256; i++) mem[i] = img[i];
        model_run();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check({"R1 reset state ", name}, {pc_out, acc_out, flags_out, halted, mem_fetch, mem_store},
              {12'h000, 16'h0000, 3'b000, 3'b000});
        while (!halted && cyc < RUN_LIMIT) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
        check({"R9 cycles to halt ", name}, cyc, m_cycles);
        check({"R3 accumulator ", name}, acc_out, m_acc);
        check({"R6 flags ", name}, flags_out, m_flags);
        check({"R2 R7 program counter ", name}, pc_out, m_pc);
        check({"R4 R5 pending stores ", name}, exp_q.size(), 0);
        for (int i = 0; i < 256; i++) if (mem[i] !== img[i]) bad++;
        check({"R4 R5 memory image ", name}, bad, 0);
        hp = pc_out; ha = acc_out; hf = flags_out; bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mem_fetch || mem_store || !halted || pc_out !== hp || acc_out !== ha || flags_out !== hf) bad++;
        end
        check({"R8 halt freeze ", name}, bad, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Arithmetic, wrap, store, clear, increment, decrement, compare-equal
        for (int i = 0; i < 256; i++) img[i] = '0;
        img[0] = 16'h0040; img[1] = 16'h3041; img[2] = 16'h1050; img[3] = 16'h5042;
        img[4] = 16'h4043; img[5] = 16'h6044; img[6] = 16'h2045; img[7] = 16'h1046;
        img[8] = 16'h7047; img[9] = 16'hF000;
        img[8'h40] = 16'hFFFF; img[8'h41] = 16'h0003; img[8'h42] = 16'h0005;
        img[8'h43] = 16'hFFFF; img[8'h44] = 16'h0000; img[8'h45] = 16'h1234;
        img[8'h46] = 16'hAAAA; img[8'h47] = 16'hFFFD;
        run_program("arith");

        // Countdown loop with backward conditional jump
        for (int i = 0; i < 256; i++) img[i] = '0;
        img[0] = 16'h6030; img[1] = 16'h0030; img[2] = 16'h7032; img[3] = 16'hB000;
        img[4] = 16'hF000;
        img[8'h30] = 16'h0003; img[8'h32] = 16'h0000;
        run_program("loop");

        // Every jump condition against greater, equal and smaller operands
        for (int j = 8; j < 15; j++) begin
            for (int v = 3; v <= 7; v += 2) begin
                for (int i = 0; i < 256; i++) img[i] = '0;
                img[0] = 16'h0030; img[1] = 16'h7031;
                img[2] = {j[3:0], 12'h005};
                img[3] = 16'h1060; img[4] = 16'hF000;
                img[5] = 16'h2061; img[6] = 16'hF000;
                img[8'h30] = 16'h0005; img[8'h31] = v[15:0]; img[8'h61] = 16'hFFFF;
                run_program($sformatf("R7 jump op=%0h v=%0d", j, v));
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule